// File: doc/BRIEF.md
# Dual-Clock Shared Word Memory with Burst Address Counters

This block is a synchronous memory array with two fully independent ports, left and right, each running on its own clock. Either port may read or write any word at any time, including the word the other port is using. Each port carries a private address counter, so a host can load a start address once and then step through consecutive words without presenting addresses again. A counter can also be cleared to word 0 in the same edge as an access.

Every port has two chip selects of opposite polarity, a read/write strobe, two byte-lane enables, an asynchronous output enable and a latency mode pin choosing one-stage (flow-through) or two-stage (pipelined) read data. Data in and data out are separate buses, and a per-lane drive flag stands in for tri-state output control. When both ports write the same word in overlapping cycles the stored value is undefined. Depth is set by `ADDR_W` and kept small by default.

Top module: `dpram_burst`

## Requirements
- R1: A word written by either port is returned by later reads from either port at that address.
- R2: With the clear input low the counter goes to 0 and the access in that same edge uses address 0, whatever the load and step inputs are.
- R3: With clear high and the load strobe low, the access uses the external address and the counter takes that value.
- R4: With clear and load high, step low accesses and stores counter+1 and step high reaches the counter value again; stepping from the top address wraps to 0.
- R5: With mode low (flow-through) read data and drive flags appear after the edge that samples the read; with mode high (pipelined) they appear one edge later.
- R6: A port is selected only when ce0 is low and ce1 is high; a deselected port neither writes nor raises its drive flags, though its counter still operates.
- R7: The upper lane is bits DATA_W-1 down to DATA_W/2 and the lower lane the bits below; upper/lower enables (active low) gate writes per lane, drive flag bit 1 belongs to the upper lane and bit 0 to the lower, and data bits of a lane not read are 0.
- R8: Output enable high forces both drive flags to 0 at once, with no clock, leaving the data value unchanged.
- R9: While rst_ni is low the counters clear and all read data and drive flags are 0.
- R10: The read/write strobe high reads and low writes; a write cycle produces no read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low, both ports |
| l_clk_i | input | 1 | Left port clock |
| l_ce0_ni | input | 1 | Left select, active low |
| l_ce1_i | input | 1 | Left select, active high |
| l_rw_ni | input | 1 | Left read (1) / write (0) |
| l_ub_ni | input | 1 | Left upper lane enable, active low |
| l_lb_ni | input | 1 | Left lower lane enable, active low |
| l_oe_ni | input | 1 | Left output enable, active low, asynchronous |
| l_pipe_i | input | 1 | Left latency mode, 1 = pipelined |
| l_clr_ni | input | 1 | Left counter clear, active low |
| l_load_ni | input | 1 | Left address load strobe, active low |
| l_step_ni | input | 1 | Left counter step enable, active low |
| l_addr_i | input | ADDR_W | Left external address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left read data |
| l_drive_o | output | 2 | Left lane drive flags {upper, lower} |
| r_clk_i | input | 1 | Right port clock |
| r_ce0_ni | input | 1 | Right select, active low |
| r_ce1_i | input | 1 | Right select, active high |
| r_rw_ni | input | 1 | Right read (1) / write (0) |
| r_ub_ni | input | 1 | Right upper lane enable, active low |
| r_lb_ni | input | 1 | Right lower lane enable, active low |
| r_oe_ni | input | 1 | Right output enable, active low, asynchronous |
| r_pipe_i | input | 1 | Right latency mode, 1 = pipelined |
| r_clr_ni | input | 1 | Right counter clear, active low |
| r_load_ni | input | 1 | Right address load strobe, active low |
| r_step_ni | input | 1 | Right counter step enable, active low |
| r_addr_i | input | ADDR_W | Right external address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right read data |
| r_drive_o | output | 2 | Right lane drive flags {upper, lower} |

## Verification
In flow-through mode a read sampled at edge k is due in the cycle after edge k, so the bench drives each vector on the falling edge, waits one rising edge and compares at the next falling edge, where it also drives the following vector. In pipelined mode the same read is checked at two falling edges: absent after edge k and present after edge k+1. The output enable is checked a few nanoseconds after it moves, well before the next rising edge, to show it needs no clock. Cross-port visibility is checked only after the writing port has finished its edge and several cycles of the reading port have passed.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_STEP = 2'd1,
    CTR_LOAD = 2'd2,
    CTR_CLR  = 2'd3
  } ctr_op_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/dpram_addr_ctr.sv
module dpram_addr_ctr
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              load_ni,
  input  logic              step_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr_o
);
  ctr_op_e           op;
  logic [ADDR_W-1:0] ctr_q, ctr_d;

  // priority: clear, load, step, hold
  always_comb begin
    if (!clr_ni)       op = CTR_CLR;
    else if (!load_ni) op = CTR_LOAD;
    else if (!step_ni) op = CTR_STEP;
    else               op = CTR_HOLD;
  end

  always_comb begin
    unique case (op)
      CTR_CLR:  ctr_d = '0;
      CTR_LOAD: ctr_d = addr_i;
      CTR_STEP: ctr_d = ctr_q + 1'b1;
      default:  ctr_d = ctr_q;
    endcase
  end

  // the access of this edge uses the value the counter moves to
  assign acc_addr_o = ctr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctr_q <= '0;
    else         ctr_q <= ctr_d;
  end

  // R2
  clr_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> ctr_q == '0);
  // R3
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !load_ni |=> ctr_q == $past(addr_i));
  // R4
  hold_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && step_ni |=> $stable(ctr_q));
  // R4
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !step_ni |=> ctr_q == $past(ctr_q) + 1'b1);
  // R4
  step_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !step_ni && (ctr_q == '1) |=> ctr_q == '0);
endmodule

// File: rtl/dpram_rd_pipe.sv
module dpram_rd_pipe
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_i,
  input  logic              oe_ni,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  drive_o
);
  localparam int unsigned LO_W = DATA_W / 2;
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] s1_data_q, s2_data_q;
  logic [LANES-1:0]  s1_lane_q, s2_lane_q, out_lane;
  logic [DATA_W-1:0] masked;

  assign masked = word_i & {{HI_W{lane_en_i[1]}}, {LO_W{lane_en_i[0]}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_data_q <= '0;
      s1_lane_q <= '0;
      s2_data_q <= '0;
      s2_lane_q <= '0;
    end else begin
      s1_data_q <= masked;
      s1_lane_q <= lane_en_i;
      s2_data_q <= s1_data_q;
      s2_lane_q <= s1_lane_q;
    end
  end

  assign rdata_o  = pipe_i ? s2_data_q : s1_data_q;
  assign out_lane = pipe_i ? s2_lane_q : s1_lane_q;
  // output enable acts without a clock
  assign drive_o  = out_lane & {LANES{~oe_ni}};

  // R5
  pipe_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_i && (s1_lane_q == '0) |=> s2_lane_q == '0);
endmodule

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wword_i,
  input  logic              wflag_i,
  input  logic [ADDR_W-1:0] raddr0_i,
  input  logic [ADDR_W-1:0] raddr1_i,
  output logic [DATA_W-1:0] rword0_o,
  output logic              rflag0_o,
  output logic [DATA_W-1:0] rword1_o,
  output logic              rflag1_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [DEPTH];
  logic              flag_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      word_q[waddr_i] <= wword_i;
      flag_q[waddr_i] <= wflag_i;
    end
  end

  assign rword0_o = word_q[raddr0_i];
  assign rflag0_o = flag_q[raddr0_i];
  assign rword1_o = word_q[raddr1_i];
  assign rflag1_o = flag_q[raddr1_i];
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              rw_ni,
  input  logic              ub_ni,
  input  logic              lb_ni,
  input  logic              oe_ni,
  input  logic              pipe_i,
  input  logic              clr_ni,
  input  logic              load_ni,
  input  logic              step_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cur_word_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  drive_o
);
  localparam int unsigned LO_W = DATA_W / 2;
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic             sel;
  logic [LANES-1:0] lanes, wr_lanes, rd_lanes;
  logic [DATA_W-1:0] wmask;

  assign sel      = !ce0_ni && ce1_i;
  assign lanes    = {~ub_ni, ~lb_ni};
  assign wr_lanes = (sel && !rw_ni) ? lanes : '0;
  assign rd_lanes = (sel &&  rw_ni) ? lanes : '0;
  assign wr_en_o  = |wr_lanes;
  assign wmask    = {{HI_W{wr_lanes[1]}}, {LO_W{wr_lanes[0]}}};
  // partial writes keep the untouched lane of the newest stored word
  assign wr_word_o = (wdata_i & wmask) | (cur_word_i & ~wmask);

  dpram_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_ni    (clr_ni),
    .load_ni   (load_ni),
    .step_ni   (step_ni),
    .addr_i    (addr_i),
    .acc_addr_o(acc_addr_o)
  );

  dpram_rd_pipe #(.DATA_W(DATA_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pipe_i   (pipe_i),
    .oe_ni    (oe_ni),
    .lane_en_i(rd_lanes),
    .word_i   (cur_word_i),
    .rdata_o  (rdata_o),
    .drive_o  (drive_o)
  );

  // R6
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel && !pipe_i && $past(!pipe_i) |=> drive_o == '0);
endmodule

// File: rtl/dpram_burst.sv
module dpram_burst #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 18
) (
  input  logic              rst_ni,
  input  logic              l_clk_i,
  input  logic              l_ce0_ni,
  input  logic              l_ce1_i,
  input  logic              l_rw_ni,
  input  logic              l_ub_ni,
  input  logic              l_lb_ni,
  input  logic              l_oe_ni,
  input  logic              l_pipe_i,
  input  logic              l_clr_ni,
  input  logic              l_load_ni,
  input  logic              l_step_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [1:0]        l_drive_o,
  input  logic              r_clk_i,
  input  logic              r_ce0_ni,
  input  logic              r_ce1_i,
  input  logic              r_rw_ni,
  input  logic              r_ub_ni,
  input  logic              r_lb_ni,
  input  logic              r_oe_ni,
  input  logic              r_pipe_i,
  input  logic              r_clr_ni,
  input  logic              r_load_ni,
  input  logic              r_step_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic [1:0]        r_drive_o
);
  logic [ADDR_W-1:0] l_acc, r_acc;
  logic              l_we, r_we;
  logic [DATA_W-1:0] l_wword, r_wword, l_cur, r_cur;
  logic [DATA_W-1:0] lb_w0, lb_w1, rb_w0, rb_w1;
  logic              lb_f0, lb_f1, rb_f0, rb_f1;

  // each port owns one copy; left copy is newest where the flags differ
  assign l_cur = (lb_f0 != rb_f0) ? lb_w0 : rb_w0;
  assign r_cur = (lb_f1 != rb_f1) ? lb_w1 : rb_w1;

  dpram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank_l (
    .clk_i(l_clk_i), .we_i(l_we), .waddr_i(l_acc), .wword_i(l_wword),
    .wflag_i(~rb_f0),
    .raddr0_i(l_acc), .raddr1_i(r_acc),
    .rword0_o(lb_w0), .rflag0_o(lb_f0), .rword1_o(lb_w1), .rflag1_o(lb_f1)
  );

  dpram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank_r (
    .clk_i(r_clk_i), .we_i(r_we), .waddr_i(r_acc), .wword_i(r_wword),
    .wflag_i(lb_f1),
    .raddr0_i(l_acc), .raddr1_i(r_acc),
    .rword0_o(rb_w0), .rflag0_o(rb_f0), .rword1_o(rb_w1), .rflag1_o(rb_f1)
  );

  dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_l (
    .clk_i(l_clk_i), .rst_ni(rst_ni),
    .ce0_ni(l_ce0_ni), .ce1_i(l_ce1_i), .rw_ni(l_rw_ni),
    .ub_ni(l_ub_ni), .lb_ni(l_lb_ni), .oe_ni(l_oe_ni), .pipe_i(l_pipe_i),
    .clr_ni(l_clr_ni), .load_ni(l_load_ni), .step_ni(l_step_ni),
    .addr_i(l_addr_i), .wdata_i(l_wdata_i), .cur_word_i(l_cur),
    .acc_addr_o(l_acc), .wr_en_o(l_we), .wr_word_o(l_wword),
    .rdata_o(l_rdata_o), .drive_o(l_drive_o)
  );

  dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_r (
    .clk_i(r_clk_i), .rst_ni(rst_ni),
    .ce0_ni(r_ce0_ni), .ce1_i(r_ce1_i), .rw_ni(r_rw_ni),
    .ub_ni(r_ub_ni), .lb_ni(r_lb_ni), .oe_ni(r_oe_ni), .pipe_i(r_pipe_i),
    .clr_ni(r_clr_ni), .load_ni(r_load_ni), .step_ni(r_step_ni),
    .addr_i(r_addr_i), .wdata_i(r_wdata_i), .cur_word_i(r_cur),
    .acc_addr_o(r_acc), .wr_en_o(r_we), .wr_word_o(r_wword),
    .rdata_o(r_rdata_o), .drive_o(r_drive_o)
  );

  // R8
  l_oe_off_chk: assert property (@(posedge l_clk_i) disable iff (!rst_ni)
    l_oe_ni |-> l_drive_o == 2'b00);
endmodule

// File: tb/dpram_burst_tb.sv
module dpram_burst_tb;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 18;

  typedef struct packed {
    logic [3:0]    req;
    logic          clr_n, load_n, step_n, rw_n, ub_n, lb_n, ce0_n, ce1;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [1:0]    xdrv;
    logic [DW-1:0] xrd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1,0,1,0,0,0,0,1, 4'd3,  18'h12345, 2'b00, 18'h0},     // R3 load, write
    '{4'd4,  1,1,0,0,0,0,0,1, 4'd0,  18'h0ABCD, 2'b00, 18'h0},     // R4 step write
    '{4'd4,  1,1,0,0,0,0,0,1, 4'd0,  18'h3FFFF, 2'b00, 18'h0},
    '{4'd3,  1,0,1,0,0,0,0,1, 4'd15, 18'h2AAAA, 2'b00, 18'h0},
    '{4'd4,  1,1,0,0,0,0,0,1, 4'd0,  18'h15555, 2'b00, 18'h0},     // wrap to 0
    '{4'd3,  1,0,1,1,0,0,0,1, 4'd3,  18'h0,     2'b11, 18'h12345}, // R3 load read
    '{4'd4,  1,1,0,1,0,0,0,1, 4'd0,  18'h0,     2'b11, 18'h0ABCD},
    '{4'd4,  1,1,1,1,0,0,0,1, 4'd0,  18'h0,     2'b11, 18'h0ABCD}, // R4 hold
    '{4'd4,  1,1,0,1,0,0,0,1, 4'd0,  18'h0,     2'b11, 18'h3FFFF},
    '{4'd3,  1,0,1,1,0,0,0,1, 4'd15, 18'h0,     2'b11, 18'h2AAAA},
    '{4'd4,  1,1,0,1,0,0,0,1, 4'd0,  18'h0,     2'b11, 18'h15555}, // R4 wrap
    '{4'd2,  0,0,1,1,0,0,0,1, 4'd9,  18'h0,     2'b11, 18'h15555}, // R2 clear beats load
    '{4'd7,  1,0,1,0,1,0,0,1, 4'd4,  18'h3FFFF, 2'b00, 18'h0},     // R7 lower lane write
    '{4'd7,  1,1,1,1,0,0,0,1, 4'd0,  18'h0,     2'b11, 18'h0ABFF},
    '{4'd7,  1,1,1,0,0,1,0,1, 4'd0,  18'h3FE00, 2'b00, 18'h0},     // R7 upper lane write
    '{4'd7,  1,1,1,1,0,1,0,1, 4'd0,  18'h0,     2'b10, 18'h3FE00}, // R7 upper read
    '{4'd7,  1,1,1,1,1,0,0,1, 4'd0,  18'h0,     2'b01, 18'h001FF}, // R7 lower read
    '{4'd6,  1,0,1,1,0,0,1,1, 4'd3,  18'h0,     2'b00, 18'h0},     // R6 ce0 high
    '{4'd6,  1,1,0,0,0,0,0,0, 4'd0,  18'h0,     2'b00, 18'h0},     // R6 ce1 low write
    '{4'd6,  1,1,1,1,0,0,0,1, 4'd0,  18'h0,     2'b11, 18'h3FFFF}, // R6 word 4 untouched
    '{4'd7,  1,1,1,0,1,1,0,1, 4'd0,  18'h0,     2'b00, 18'h0},     // R7 no lanes
    '{4'd7,  1,1,1,1,0,0,0,1, 4'd0,  18'h0,     2'b11, 18'h3FFFF}
  };

  logic          rst_ni;
  logic          l_clk, r_clk;
  logic          l_ce0_n, l_ce1, l_rw_n, l_ub_n, l_lb_n, l_oe_n, l_pipe;
  logic          l_clr_n, l_load_n, l_step_n;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wd, l_rd;
  logic [1:0]    l_drv;
  logic          r_ce0_n, r_ce1, r_rw_n, r_ub_n, r_lb_n, r_oe_n, r_pipe;
  logic          r_clr_n, r_load_n, r_step_n;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wd, r_rd;
  logic [1:0]    r_drv;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .rst_ni(rst_ni),
    .l_clk_i(l_clk), .l_ce0_ni(l_ce0_n), .l_ce1_i(l_ce1), .l_rw_ni(l_rw_n),
    .l_ub_ni(l_ub_n), .l_lb_ni(l_lb_n), .l_oe_ni(l_oe_n), .l_pipe_i(l_pipe),
    .l_clr_ni(l_clr_n), .l_load_ni(l_load_n), .l_step_ni(l_step_n),
    .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_rdata_o(l_rd), .l_drive_o(l_drv),
    .r_clk_i(r_clk), .r_ce0_ni(r_ce0_n), .r_ce1_i(r_ce1), .r_rw_ni(r_rw_n),
    .r_ub_ni(r_ub_n), .r_lb_ni(r_lb_n), .r_oe_ni(r_oe_n), .r_pipe_i(r_pipe),
    .r_clr_ni(r_clr_n), .r_load_ni(r_load_n), .r_step_ni(r_step_n),
    .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_rdata_o(r_rd), .r_drive_o(r_drv)
  );

  initial l_clk = 1'b0;
  always #10 l_clk = ~l_clk;
  initial r_clk = 1'b0;
  always #13 r_clk = ~r_clk;

  task automatic chk(input string req, input logic [DW-1:0] ad, input logic [DW-1:0] xd,
                     input logic [1:0] av, input logic [1:0] xv);
    total++;
    if (ad !== xd || av !== xv) begin
      fails++;
      $display("FAIL %s: data %h drive %b, expected data %h drive %b", req, ad, av, xd, xv);
    end
  endtask

  task automatic l_apply(input vec_t v);
    l_clr_n = v.clr_n; l_load_n = v.load_n; l_step_n = v.step_n; l_rw_n = v.rw_n;
    l_ub_n = v.ub_n; l_lb_n = v.lb_n; l_ce0_n = v.ce0_n; l_ce1 = v.ce1;
    l_addr = v.addr; l_wd = v.wd;
  endtask

  task automatic l_idle();
    l_clr_n = 1; l_load_n = 1; l_step_n = 1; l_rw_n = 1;
    l_ub_n = 1; l_lb_n = 1; l_ce0_n = 1; l_ce1 = 0; l_addr = '0; l_wd = '0;
  endtask

  task automatic r_idle();
    r_clr_n = 1; r_load_n = 1; r_step_n = 1; r_rw_n = 1;
    r_ub_n = 1; r_lb_n = 1; r_ce0_n = 1; r_ce1 = 0; r_addr = '0; r_wd = '0;
  endtask

  task automatic l_op(input logic ld_n, input logic st_n, input logic rw, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    l_clr_n = 1; l_load_n = ld_n; l_step_n = st_n; l_rw_n = rw;
    l_ub_n = 0; l_lb_n = 0; l_ce0_n = 0; l_ce1 = 1; l_addr = a; l_wd = d;
  endtask

  task automatic r_op(input logic ld_n, input logic st_n, input logic rw, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    r_clr_n = 1; r_load_n = ld_n; r_step_n = st_n; r_rw_n = rw;
    r_ub_n = 0; r_lb_n = 0; r_ce0_n = 0; r_ce1 = 1; r_addr = a; r_wd = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    total++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_ni = 0; l_oe_n = 0; r_oe_n = 0; l_pipe = 0; r_pipe = 0;
    l_idle(); r_idle();
    repeat (3) @(posedge l_clk);
    @(negedge l_clk);
    chk("R9 left reset", l_rd, '0, l_drv, 2'b00);
    chk("R9 right reset", r_rd, '0, r_drv, 2'b00);
    rst_ni = 1;

    // table walk, left port, flow-through: result due one edge after its vector
    @(negedge l_clk);
    for (int i = 0; i < NV; i++) begin
      l_apply(VECS[i]);
      @(posedge l_clk);
      @(negedge l_clk);
      chk($sformatf("R%0d vec %0d (R5 R10 flow)", VECS[i].req, i), l_rd, VECS[i].xrd,
          l_drv, VECS[i].xdrv);
    end

    // R8: output enable without a clock
    l_op(0, 1, 1, 4'd3, '0);
    @(posedge l_clk);
    @(negedge l_clk);
    chk("R8 enabled", l_rd, 18'h12345, l_drv, 2'b11);
    #2 l_oe_n = 1;
    #1 chk("R8 disabled async", l_rd, 18'h12345, l_drv, 2'b00);
    l_oe_n = 0;
    #1 chk("R8 re-enabled async", l_rd, 18'h12345, l_drv, 2'b11);

    // R5: pipelined latency
    @(negedge l_clk);
    l_idle();
    l_pipe = 1;
    repeat (2) @(posedge l_clk);
    @(negedge l_clk);
    l_op(0, 1, 1, 4'd5, '0);
    @(posedge l_clk);
    @(negedge l_clk);
    chk("R5 pipelined not yet", l_rd, '0, l_drv, 2'b00);
    l_idle();
    @(posedge l_clk);
    @(negedge l_clk);
    chk("R5 pipelined due", l_rd, 18'h3FFFF, l_drv, 2'b11);
    @(posedge l_clk);
    @(negedge l_clk);
    chk("R5 pipelined gone", l_rd, '0, l_drv, 2'b00);
    l_pipe = 0;

    // R1: right port writes and reads words from the left port
    @(negedge r_clk);
    r_op(0, 1, 0, 4'd6, 18'h1F0F0);
    @(negedge r_clk);
    r_op(0, 1, 1, 4'd15, '0);
    @(posedge r_clk);
    @(negedge r_clk);
    chk("R1 right reads left word", r_rd, 18'h2AAAA, r_drv, 2'b11);
    r_op(1, 0, 1, 4'd0, '0);
    @(posedge r_clk);
    @(negedge r_clk);
    chk("R1 R4 right step wraps", r_rd, 18'h15555, r_drv, 2'b11);
    r_idle();
    repeat (3) @(posedge l_clk);
    @(negedge l_clk);
    l_op(0, 1, 1, 4'd6, '0);
    @(posedge l_clk);
    @(negedge l_clk);
    chk("R1 left reads right word", l_rd, 18'h1F0F0, l_drv, 2'b11);
    l_idle();

    // R2: clear with no load, access at address 0 in the same edge
    l_op(1, 0, 1, 4'd0, '0);
    l_clr_n = 0;
    @(posedge l_clk);
    @(negedge l_clk);
    chk("R2 clear then read 0", l_rd, 18'h15555, l_drv, 2'b11);
    l_idle();
    @(posedge l_clk);
    @(negedge l_clk);
    finish_run();
  end
endmodule